// File: doc/BRIEF.md
# Bus Grant Controller

This block handles the grant side of a processor's bus interface. An alternate master raises a bus request. The block passes that request through a synchronizer and then asserts a bus grant. It also raises a three-state control, which floats the processor's address, data and strobe drivers while the other master owns the bus. When the other master gives the bus back, the block drops the three-state control, and the processor may then start its next bus cycle.

A static input selects one of two handshakes. In the three-wire handshake, the alternate master answers the grant with a grant-acknowledge and holds that signal for as long as it owns the bus. In the two-wire handshake there is no acknowledge: ownership lasts for as long as the request stays asserted.

Two inputs come from the processor's own bus-cycle sequencer. The first marks the first two phases of a bus cycle; while it is high, the arbitration state is frozen. The second is the processor's address strobe. The drivers float only once the strobe is negated, so an idle processor floats its bus in the same cycle that grant rises.

Top module: `busgrant_ctl`

## Requirements
- R1: While reset is asserted (rst_n low), and just after it is released, grant, tri_req and bus_float are all 0.
- R2: Suppose breq_in rises between clock edges and cyc_head is low. Then grant and tri_req stay 0 after the next two rising edges and both read 1 after the third.
- R3: While cyc_head is 1, the arbitration state does not change: grant and tri_req keep their values across the edge. A request that became valid while frozen is granted at the first edge at which cyc_head is 0.
- R4: bus_float is 1 exactly when tri_req is 1 and addr_strobe is 0. This follows addr_strobe within the same cycle, so a request made while the processor is inactive floats the bus together with grant.
- R5: In three-wire mode (three_wire = 1), back_in rising while grant is 1 makes grant read 0 after the third rising edge, while tri_req stays 1.
- R6: In three-wire mode, once back_in falls during ownership, tri_req stays 1 for three rising edges and reads 0 after the fourth.
- R7: In two-wire mode (three_wire = 0), back_in has no effect: grant stays 1 while breq_in is held. When breq_in falls, grant reads 0 after the third rising edge and tri_req reads 0 after the fourth.
- R8: grant is never 1 while tri_req is 0.
- R9: In three-wire mode, if breq_in falls before any acknowledge, grant reads 0 after the third rising edge and tri_req reads 0 after the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| three_wire | input | 1 | 1 selects the three-wire handshake, 0 the two-wire handshake; static |
| breq_in | input | 1 | Bus request from the alternate master, active high, asynchronous |
| back_in | input | 1 | Grant-acknowledge from the alternate master, active high, asynchronous |
| cyc_head | input | 1 | High during the first two phases of a processor bus cycle |
| addr_strobe | input | 1 | Processor address strobe, active high |
| grant | output | 1 | Bus grant to the alternate master |
| tri_req | output | 1 | Three-state control: the alternate master holds or is taking the bus |
| bus_float | output | 1 | Float enable for the processor's address, data and strobe drivers |

## Verification
A wrong state shows up at the ports within four clock edges of the stimulus, in one of three ways:
- a grant that rises an edge early or late;
- a three-state control that drops while the other master still holds the bus;
- a float that ignores the address strobe.

A freeze that does not hold shows up as grant rising during a cycle-head window that lasts longer than the synchronizer delay. A mode mix-up shows up as grant following the acknowledge in two-wire operation. Every handshake is run in both modes and with the strobe both high and low, so that each of these states is reached and checked at its exact edge.

// File: rtl/busgrant_ctl.sv
module busgrant_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic three_wire,
  input  logic breq_in,
  input  logic back_in,
  input  logic cyc_head,
  input  logic addr_strobe,
  output logic grant,
  output logic tri_req,
  output logic bus_float
);
  typedef enum logic [1:0] {ST_IDLE, ST_GRANT, ST_HELD, ST_FREE} st_t;

  st_t        state, nxt;
  logic [1:0] req_q, ack_q;
  logic       req_v, ack_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      ack_q <= '0;
    end else begin
      req_q <= {req_q[0], breq_in};
      ack_q <= {ack_q[0], back_in};
    end
  end

  assign req_v = req_q[1];
  assign ack_v = three_wire & ack_q[1];

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_v) nxt = ST_GRANT;
      ST_GRANT: begin
        if (ack_v)       nxt = ST_HELD;
        else if (!req_v) nxt = ST_FREE;
      end
      ST_HELD:  if (!ack_v) nxt = ST_FREE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         state <= ST_IDLE;
    else if (!cyc_head) state <= nxt;
  end

  assign grant     = (state == ST_GRANT);
  assign tri_req   = (state != ST_IDLE);
  assign bus_float = tri_req & ~addr_strobe;
endmodule

// File: rtl/busgrant_ctl_chk.sv
module busgrant_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic three_wire,
  input logic cyc_head,
  input logic addr_strobe,
  input logic grant,
  input logic tri_req,
  input logic bus_float
);
  assert_grant_needs_tri_R8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> tri_req);

  assert_float_needs_tri_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float |-> tri_req);

  assert_float_waits_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_float |-> !addr_strobe);

  assert_frozen_in_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_head |=> ($stable(grant) && $stable(tri_req)));

  assert_release_after_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tri_req) |-> !grant);

  assert_two_wire_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!three_wire && $fell(grant)) |-> tri_req);
endmodule

bind busgrant_ctl busgrant_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .cyc_head(cyc_head),
  .addr_strobe(addr_strobe), .grant(grant), .tri_req(tri_req), .bus_float(bus_float)
);

// File: tb/busgrant_ctl_tb.sv
module busgrant_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, three_wire, breq_in, back_in, cyc_head, addr_strobe;
  logic grant, tri_req, bus_float;
  int   n_run = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busgrant_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .three_wire(three_wire), .breq_in(breq_in),
    .back_in(back_in), .cyc_head(cyc_head), .addr_strobe(addr_strobe),
    .grant(grant), .tri_req(tri_req), .bus_float(bus_float)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; three_wire = 1; breq_in = 1; back_in = 0; cyc_head = 0; addr_strobe = 0;
    step(4);
    chk("R1 grant in reset", grant, 0);
    chk("R1 tri in reset", tri_req, 0);
    chk("R1 float in reset", bus_float, 0);
    breq_in = 0;
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 grant after reset", grant, 0);
    chk("R1 tri after reset", tri_req, 0);

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 2; a++) begin
        three_wire = logic'(m); addr_strobe = logic'(a);
        breq_in = 1;
        step(2);
        chk("R2 grant not yet", grant, 0);
        chk("R2 tri not yet", tri_req, 0);
        step(1);
        chk("R2 grant", grant, 1);
        chk("R2 tri", tri_req, 1);
        chk("R4 float vs strobe", bus_float, logic'(!a));
        addr_strobe = ~addr_strobe; #1;
        chk("R4 float follows strobe", bus_float, logic'(a));
        addr_strobe = logic'(a);
        if (m == 1) begin
          back_in = 1; breq_in = 0;
          step(2);
          chk("R5 grant before ack sync", grant, 1);
          step(1);
          chk("R5 grant dropped on ack", grant, 0);
          chk("R5 tri held", tri_req, 1);
          step(5);
          chk("R6 tri held while ack", tri_req, 1);
          back_in = 0;
          step(3);
          chk("R6 tri still held", tri_req, 1);
          step(1);
          chk("R6 tri released", tri_req, 0);
          chk("R6 float released", bus_float, 0);
        end else begin
          back_in = 1;
          step(5);
          chk("R7 ack ignored grant", grant, 1);
          breq_in = 0;
          step(2);
          chk("R7 grant before drop sync", grant, 1);
          step(1);
          chk("R7 grant dropped", grant, 0);
          chk("R7 tri held", tri_req, 1);
          step(1);
          chk("R7 tri released", tri_req, 0);
          back_in = 0;
        end
        step(3);
      end
    end

    three_wire = 1; addr_strobe = 0;
    breq_in = 1;
    step(3);
    chk("R9 granted", grant, 1);
    breq_in = 0;
    step(3);
    chk("R9 grant dropped", grant, 0);
    chk("R9 tri held", tri_req, 1);
    step(1);
    chk("R9 tri released", tri_req, 0);
    step(3);

    three_wire = 0;
    for (int f = 1; f <= 4; f++) begin
      cyc_head = 1; breq_in = 1;
      step(2 + f);
      chk("R3 frozen no grant", grant, 0);
      chk("R3 frozen no tri", tri_req, 0);
      cyc_head = 0;
      step(1);
      chk("R3 grant after thaw", grant, 1);
      cyc_head = 1; breq_in = 0;
      step(3 + f);
      chk("R3 frozen grant held", grant, 1);
      chk("R8 tri with grant", tri_req, 1);
      cyc_head = 0;
      step(1);
      chk("R3 grant drop after thaw", grant, 0);
      step(1);
      chk("R3 tri release", tri_req, 0);
      step(3);
    end

    breq_in = 1;
    step(3);
    chk("R1 granted before reset", grant, 1);
    rst_n = 0;
    step(1);
    chk("R1 grant cleared by reset", grant, 0);
    chk("R1 tri cleared by reset", tri_req, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule